// File: doc/BRIEF.md
# Memory-Mapped UART Register and FIFO Front End

This block is the register file and byte-queue front end of a simple UART. A host reaches seven 32-bit registers over a one-request-per-cycle bus: a transmit data port, a receive data port, a transmit control word, a receive control word, an interrupt enable word, a read-only interrupt pending word and a baud divisor. Bytes written to the transmit port queue in a transmit FIFO and leave through a byte-wide valid/ready source. Bytes arriving on a byte-wide valid/ready sink queue in a receive FIFO and are taken by reading the receive port. The serial shifter and baud generator sit outside. The divisor is only stored and driven out.

Every bus request is answered one cycle later with a registered read word. Only whole-word accesses, with all four byte strobes set and an aligned offset, take effect. Two watermark pending bits compare each FIFO's occupancy with a 3-bit count field in its control word. One level interrupt line is derived from the enable bits and the receive FIFO state.

Register offsets: 0x00 transmit data, 0x04 receive data, 0x08 transmit control, 0x0C receive control, 0x10 interrupt enable, 0x14 interrupt pending, 0x18 divisor. The count fields are bits 18:16 of both control words. In the enable and pending words, bit 0 is the transmit watermark and bit 1 is the receive watermark.

Top module: `uart_mmio_front`

## Requirements
- R1: After reset every register reads zero, except the receive port, which reads 0x80000000. `irq` is low, `tx_valid` is low, `rx_ready` is high and `baud_div` is zero.
- R2: A whole-word read of offset 0x04 returns the oldest received byte in bits 7:0, with bits 31:8 zero, and removes it. With the receive FIFO empty it returns 0x80000000 and removes nothing. Bytes come out in arrival order.
- R3: A whole-word write to offset 0x00 queues bits 7:0 of the word. A write while the 8-entry transmit FIFO is full is discarded. Queued bytes leave on `tx_data` in write order, one per cycle in which `tx_valid` and `tx_ready` are both high.
- R4: A read of offset 0x00 returns bit 31 set exactly while the transmit FIFO holds 8 bytes, and all other bits zero. The bit clears once a byte drains.
- R5: `rx_ready` is low while the receive FIFO holds 8 bytes. A byte offered then is dropped.
- R6: Pending bit 1 reads 1 exactly when the receive occupancy is strictly greater than bits 18:16 of the receive control word.
- R7: Pending bit 0 reads 1 exactly when the transmit occupancy is strictly less than bits 18:16 of the transmit control word.
- R8: `irq` is high when enable bit 0 is set, or when enable bit 1 is set and the receive FIFO is non-empty. Otherwise it is low. It follows the state left by each write, push or pop.
- R9: Offsets 0x08, 0x0C, 0x10 and 0x18 read back the whole last word written, and `baud_div` equals the word at 0x18.
- R10: A write to offset 0x14 changes nothing.
- R11: A request whose byte strobes are not all ones has no effect, and a read of that kind returns zero without popping.
- R12: Unmapped or misaligned offsets read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 5 | Byte offset of the register |
| req_be | input | 4 | Byte strobes; all ones required |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response valid, one cycle after a read request |
| rsp_rdata | output | 32 | Read response data |
| tx_valid | output | 1 | Transmit byte available |
| tx_ready | input | 1 | Downstream takes the byte |
| tx_data | output | 8 | Transmit byte |
| rx_valid | input | 1 | Incoming byte offered |
| rx_ready | output | 1 | Receive FIFO has room |
| rx_data | input | 8 | Incoming byte |
| baud_div | output | 32 | Stored divisor word |
| irq | output | 1 | Level interrupt |

## Verification
The hardest states to reach are the full-queue boundaries. In these, a ninth byte must vanish without disturbing the eight already held, while the watermark comparisons and the transmit full flag must switch at exactly the right occupancy. The bench holds `tx_ready` low so that the transmit queue can only grow. It then walks both queues one entry at a time from empty to full and one past. At every occupancy it sweeps all eight count-field values and compares the pending word with the arithmetic result. Draining afterwards shows that the order is intact and that nothing extra was stored.

// File: rtl/uart_mmio_pkg.sv
package uart_mmio_pkg;

  localparam int unsigned WORD_W  = 32;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned THR_LSB = 16;
  localparam int unsigned THR_W   = 3;
  localparam int unsigned TXWM_BIT = 0;
  localparam int unsigned RXWM_BIT = 1;
  localparam int unsigned FLAG_BIT = 31;

  // word index order defines the register offsets
  typedef enum logic [2:0] {
    SEL_TXD  = 3'd0,
    SEL_RXD  = 3'd1,
    SEL_TXC  = 3'd2,
    SEL_RXC  = 3'd3,
    SEL_IEN  = 3'd4,
    SEL_IPD  = 3'd5,
    SEL_DIV  = 3'd6,
    SEL_NONE = 3'd7
  } reg_sel_e;

endpackage

// File: rtl/uart_mmio_fifo.sv
module uart_mmio_fifo #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_en,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop_en,
  output logic             push_ok,
  output logic             pop_ok,
  output logic [WIDTH-1:0] head,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign push_ok = push_en && !full;
  assign pop_ok  = pop_en && !empty;
  assign head    = mem_q[rd_ptr_q];
  assign count   = cnt_q;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    if (p == PTR_W'(DEPTH - 1)) return '0;
    return p + PTR_W'(1);
  endfunction

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (push_ok) wr_ptr_d = ptr_inc(wr_ptr_q);
    if (pop_ok)  rd_ptr_d = ptr_inc(rd_ptr_q);
    cnt_d = cnt_q + CNT_W'(push_ok) - CNT_W'(pop_ok);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  // storage carries no reset; only written entries are ever read
  always_ff @(posedge clk) begin
    if (push_ok) mem_q[wr_ptr_q] <= push_data;
  end

  AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) (full && push_en && !pop_en) |=> (count == $past(count))); // R5
  AST_FIFO_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (empty && pop_en && !push_en) |=> (count == '0)); // R2

endmodule

// File: rtl/uart_mmio_decode.sv
module uart_mmio_decode
  import uart_mmio_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  localparam int unsigned IDX_W = ADDR_W - 2
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_be,
  output logic              wr_stb,
  output logic              rd_stb,
  output logic              rd_any,
  output reg_sel_e          sel
);

  logic [IDX_W-1:0] idx;
  logic             whole;
  logic             mapped;

  assign idx    = req_addr[ADDR_W-1:2];
  assign whole  = (req_be == 4'hF);
  assign mapped = (req_addr[1:0] == 2'b00) && (idx <= IDX_W'(SEL_DIV));

  always_comb begin
    sel = SEL_NONE;
    if (mapped) sel = reg_sel_e'(idx[2:0]);
  end

  assign rd_any = req_valid && !req_write;
  assign rd_stb = rd_any && whole && mapped;
  assign wr_stb = req_valid && req_write && whole && mapped;

endmodule

// File: rtl/uart_mmio_regs.sv
module uart_mmio_regs
  import uart_mmio_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic              rd_stb,
  input  logic              rd_any,
  input  reg_sel_e          sel,
  input  logic [WORD_W-1:0] wdata,
  input  logic [BYTE_W-1:0] rx_head,
  input  logic              rx_empty,
  input  logic [CNT_W-1:0]  rx_count,
  input  logic [CNT_W-1:0]  tx_count,
  input  logic              tx_flag,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_rdata,
  output logic [WORD_W-1:0] baud_div,
  output logic              irq
);

  logic [WORD_W-1:0] ien_q, ien_d;
  logic [WORD_W-1:0] txc_q, txc_d;
  logic [WORD_W-1:0] rxc_q, rxc_d;
  logic [WORD_W-1:0] div_q, div_d;
  logic [WORD_W-1:0] rdata_q, rdata_d;
  logic              rvalid_q;
  logic [CNT_W-1:0]  tx_thr, rx_thr;
  logic              tx_pend, rx_pend;
  logic [WORD_W-1:0] pend_word;

  assign tx_thr  = CNT_W'(txc_q[THR_LSB +: THR_W]);
  assign rx_thr  = CNT_W'(rxc_q[THR_LSB +: THR_W]);
  assign tx_pend = (tx_count < tx_thr);
  assign rx_pend = (rx_count > rx_thr);

  always_comb begin
    pend_word = '0;
    pend_word[TXWM_BIT] = tx_pend;
    pend_word[RXWM_BIT] = rx_pend;
  end

  always_comb begin
    ien_d = ien_q;
    txc_d = txc_q;
    rxc_d = rxc_q;
    div_d = div_q;
    if (wr_stb) begin
      unique case (sel)
        SEL_IEN: ien_d = wdata;
        SEL_TXC: txc_d = wdata;
        SEL_RXC: rxc_d = wdata;
        SEL_DIV: div_d = wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_d = '0;
    if (rd_stb) begin
      unique case (sel)
        SEL_TXD: rdata_d[FLAG_BIT] = tx_flag;
        SEL_RXD: rdata_d = rx_empty ? (WORD_W'(1) << FLAG_BIT) : WORD_W'(rx_head);
        SEL_TXC: rdata_d = txc_q;
        SEL_RXC: rdata_d = rxc_q;
        SEL_IEN: rdata_d = ien_q;
        SEL_IPD: rdata_d = pend_word;
        SEL_DIV: rdata_d = div_q;
        default: rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q    <= '0;
      txc_q    <= '0;
      rxc_q    <= '0;
      div_q    <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      ien_q    <= ien_d;
      txc_q    <= txc_d;
      rxc_q    <= rxc_d;
      div_q    <= div_d;
      rvalid_q <= rd_any;
      if (rd_any) rdata_q <= rdata_d;
    end
  end

  assign rsp_valid = rvalid_q;
  assign rsp_rdata = rdata_q;
  assign baud_div  = div_q;
  assign irq       = ien_q[TXWM_BIT] | (ien_q[RXWM_BIT] & !rx_empty);

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (!ien_q[TXWM_BIT] && rx_empty) |-> !irq); // R8
  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !(wr_stb && sel == SEL_RXC) |=> $stable(rxc_q)); // R9

endmodule

// File: rtl/uart_mmio_front.sv
module uart_mmio_front
  import uart_mmio_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned ADDR_W = 5,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_be,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [7:0]        rx_data,
  output logic [31:0]       baud_div,
  output logic              irq
);

  logic             wr_stb, rd_stb, rd_any;
  reg_sel_e         sel;
  logic             tx_push_req, tx_push_ok, tx_pop_ok, tx_full, tx_empty;
  logic [CNT_W-1:0] tx_count;
  logic             rx_pop_req, rx_push_ok, rx_pop_ok, rx_full, rx_empty;
  logic [CNT_W-1:0] rx_count;
  logic [7:0]       rx_head;
  logic             flag_q, flag_d;

  uart_mmio_decode #(.ADDR_W(ADDR_W)) u_dec (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_be    (req_be),
    .wr_stb    (wr_stb),
    .rd_stb    (rd_stb),
    .rd_any    (rd_any),
    .sel       (sel)
  );

  assign tx_push_req = wr_stb && (sel == SEL_TXD);
  assign rx_pop_req  = rd_stb && (sel == SEL_RXD);

  uart_mmio_fifo #(.WIDTH(BYTE_W), .DEPTH(DEPTH)) u_txq (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_en   (tx_push_req),
    .push_data (req_wdata[BYTE_W-1:0]),
    .pop_en    (tx_ready),
    .push_ok   (tx_push_ok),
    .pop_ok    (tx_pop_ok),
    .head      (tx_data),
    .count     (tx_count),
    .full      (tx_full),
    .empty     (tx_empty)
  );

  uart_mmio_fifo #(.WIDTH(BYTE_W), .DEPTH(DEPTH)) u_rxq (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_en   (rx_valid),
    .push_data (rx_data),
    .pop_en    (rx_pop_req),
    .push_ok   (rx_push_ok),
    .pop_ok    (rx_pop_ok),
    .head      (rx_head),
    .count     (rx_count),
    .full      (rx_full),
    .empty     (rx_empty)
  );

  assign tx_valid = !tx_empty;
  assign rx_ready = !rx_full;

  // full flag: raised by the push that fills, dropped by any drain
  always_comb begin
    if (flag_q) flag_d = !tx_pop_ok;
    else        flag_d = tx_push_ok && !tx_pop_ok && (tx_count == CNT_W'(DEPTH - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  uart_mmio_regs #(.DEPTH(DEPTH)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_stb    (wr_stb),
    .rd_stb    (rd_stb),
    .rd_any    (rd_any),
    .sel       (sel),
    .wdata     (req_wdata),
    .rx_head   (rx_head),
    .rx_empty  (rx_empty),
    .rx_count  (rx_count),
    .tx_count  (tx_count),
    .tx_flag   (flag_q),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .baud_div  (baud_div),
    .irq       (irq)
  );

  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n) (rx_pop_req && rx_empty) |=> (rsp_rdata == 32'h8000_0000)); // R2
  AST_FLAG_TRACKS: assert property (@(posedge clk) disable iff (!rst_n) flag_q == tx_full); // R4
  AST_POP_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rst_n) rx_pop_ok |-> rx_pop_req); // R11

endmodule

// File: tb/sim_uart_mmio_front.sv
module sim_uart_mmio_front;

  localparam int CLK_P = 10;
  localparam logic [4:0] A_TXD = 5'h00, A_RXD = 5'h04, A_TXC = 5'h08,
                         A_RXC = 5'h0C, A_IEN = 5'h10, A_IPD = 5'h14, A_DIV = 5'h18;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, tx_ready, rx_valid;
  logic [4:0]  req_addr;
  logic [3:0]  req_be;
  logic [31:0] req_wdata;
  logic [7:0]  rx_data;
  logic        rsp_valid, tx_valid, rx_ready, irq;
  logic [31:0] rsp_rdata, baud_div;
  logic [7:0]  tx_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #(CLK_P/2) clk = ~clk;

  uart_mmio_front u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data), .baud_div(baud_div), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_be = be;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_be = be;
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_valid ? rsp_rdata : 32'hxxxx_xxxx;
  endtask

  task automatic rx_push(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic tx_take(output logic v, output logic [7:0] b);
    @(negedge clk);
    v = tx_valid; b = tx_data; tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic        v;
    logic [7:0]  b;
    req_valid = 0; req_write = 0; req_addr = '0; req_be = 4'hF; req_wdata = '0;
    tx_ready = 0; rx_valid = 0; rx_data = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    check("R1 irq", {31'b0, irq}, 0);
    check("R1 tx_valid", {31'b0, tx_valid}, 0);
    check("R1 rx_ready", {31'b0, rx_ready}, 1);
    check("R1 baud_div", baud_div, 0);
    rd(A_RXD, r); check("R1 rxd", r, 32'h8000_0000);
    for (int k = 0; k < 7; k++) begin
      if (k == 1) continue;
      rd(5'(k * 4), r); check("R1 reg", r, 0);
    end

    // R9 readback
    wr(A_TXC, 32'h1234_5678); wr(A_RXC, 32'h9ABC_DEF0);
    wr(A_IEN, 32'hFFFF_FFFC); wr(A_DIV, 32'h0000_01B2);
    rd(A_TXC, r); check("R9 txc", r, 32'h1234_5678);
    rd(A_RXC, r); check("R9 rxc", r, 32'h9ABC_DEF0);
    rd(A_IEN, r); check("R9 ien", r, 32'hFFFF_FFFC);
    rd(A_DIV, r); check("R9 div", r, 32'h0000_01B2);
    check("R9 baud_div", baud_div, 32'h0000_01B2);
    wr(A_TXC, 0); wr(A_RXC, 0); wr(A_IEN, 0);

    // R10 pending word is read-only
    wr(A_IPD, 32'hFFFF_FFFF); rd(A_IPD, r); check("R10 ipd", r, 0);

    // R12 unmapped / misaligned
    wr(5'h1C, 32'h0000_0003); rd(5'h1C, r); check("R12 unmapped rd", r, 0);
    wr(5'h12, 32'h0000_0003); rd(A_IEN, r); check("R12 misaligned wr", r, 0);
    check("R12 irq", {31'b0, irq}, 0);

    // R5 R6 fill receive queue, sweep threshold at each occupancy
    for (int occ = 0; occ <= 8; occ++) begin
      for (int c = 0; c < 8; c++) begin
        wr(A_RXC, 32'(c) << 16);
        rd(A_IPD, r); check("R6 rx watermark", r, {30'b0, (occ > c), 1'b0});
      end
      check("R5 rx_ready", {31'b0, rx_ready}, (occ < 8) ? 1 : 0);
      if (occ < 8) rx_push(8'h30 + 8'(occ));
    end
    rx_push(8'hEE);                      // R5 dropped while full
    wr(A_RXC, 0);

    // R11 partial strobe read returns zero, no pop; R12 misaligned read
    rd(A_RXD, r, 4'h3); check("R11 partial rd", r, 0);
    rd(5'h05, r); check("R12 misaligned rd", r, 0);

    // R8 irq with receive data held
    for (int e = 0; e < 4; e++) begin
      wr(A_IEN, 32'(e)); check("R8 irq rx full", {31'b0, irq}, (e != 0) ? 1 : 0);
    end

    // R2 drain in order
    wr(A_IEN, 32'h2);
    for (int k = 0; k < 8; k++) begin
      rd(A_RXD, r); check("R2 rx order", r, 32'h30 + k);
      check("R8 irq after pop", {31'b0, irq}, (k < 7) ? 1 : 0);
    end
    rd(A_RXD, r); check("R2 empty rd", r, 32'h8000_0000);
    rd(A_RXD, r); check("R2 empty rd again", r, 32'h8000_0000);
    for (int e = 0; e < 4; e++) begin
      wr(A_IEN, 32'(e)); check("R8 irq rx empty", {31'b0, irq}, e[0] ? 1 : 0);
    end
    wr(A_IEN, 0);

    // R11 partial strobe write ignored
    wr(A_IEN, 32'h3, 4'h1); rd(A_IEN, r); check("R11 partial wr", r, 0);
    check("R11 irq", {31'b0, irq}, 0);

    // R3 R4 R7 fill transmit queue
    for (int occ = 0; occ <= 8; occ++) begin
      for (int c = 0; c < 8; c++) begin
        wr(A_TXC, 32'(c) << 16);
        rd(A_IPD, r); check("R7 tx watermark", r, {31'b0, (occ < c)});
      end
      rd(A_TXD, r); check("R4 full flag", r, (occ == 8) ? 32'h8000_0000 : 0);
      wr(A_TXD, 32'hABCD_EF00 | 32'(8'h40 + occ));   // ninth push discarded
    end
    wr(A_TXC, 0);
    check("R3 tx_valid", {31'b0, tx_valid}, 1);
    for (int k = 0; k < 8; k++) begin
      tx_take(v, b);
      check("R3 tx valid", {31'b0, v}, 1);
      check("R3 tx order", {24'b0, b}, 32'h40 + k);
      if (k == 0) begin rd(A_TXD, r); check("R4 flag cleared", r, 0); end
    end
    @(negedge clk);
    check("R3 overflow dropped", {31'b0, tx_valid}, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule